// File: doc/BRIEF.md
# SD Command Token Encoder and Response Capture

This block is the command-line front end of an SD/MMC host controller. Software writes a 32-bit argument and then a 32-bit command word over a small register bus. The write to the command word starts the command. The block builds the 48-bit command token and shifts it out on a one-bit CMD line, one bit for each SD clock enable pulse. It then waits for the card's reply, receives a 48-bit or 136-bit response and stores response bits 127:8 in four readable registers.

Three bits of the command word select the response kind directly. The zero code asks the block to choose the kind from the command index. A busy output covers the whole exchange. Status outputs report a completed response, a missing response and a failed integrity check on short responses. The CMD line pins are plain. There is no handshake or back-pressure: the SD clock enable paces every bit, and software must wait for busy to fall before it issues the next command.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset, busy, resp_done, resp_timeout and resp_err are 0, cmd_oe is 0, cmd_out is 1, and every readable offset returns 0.
- R2: An accepted command drives a 48-bit token on cmd_out, most significant bit first, while cmd_oe is 1. The token is a start bit 0, a direction bit 1, the index from command-word bits 5:0, the 32-bit argument, a CRC7 and an end bit 1. The CRC7 uses polynomial x^7+x^3+1, starts from zero and covers the first 40 token bits. Each bit is held until the sd_tick that consumes it.
- R3: A write to offset 0x00 while busy is 0 starts a command, and busy is 1 from the next cycle. While busy is 1, writes to offset 0x00 and to offset 0x08 have no effect on the stored values or on the token being sent.
- R4: Command-word bits 10:8 select the response kind. Code 3 means no response. Codes 4 and 5 mean a checked 48-bit response. Code 7 means an unchecked 48-bit response. Code 6 means a 136-bit response. Codes 0, 1 and 2 choose the kind from the index: index 0 means no response, indices 2, 9 and 10 mean a 136-bit response, and any other index means a checked 48-bit response.
- R5: With no response expected, resp_done sets and busy clears on the tick that sends the token's end bit.
- R6: A 48-bit response sets resp_done and clears busy on the tick that carries its last bit. Response bits 39:8 are stored at offset 0x18, and offsets 0x20, 0x28 and 0x30 read 0.
- R7: A 136-bit response stores bits 39:8 at offset 0x18, bits 71:40 at 0x20, bits 103:72 at 0x28 and bits 127:104 in the low 24 bits of 0x30. The upper byte of 0x30 reads 0.
- R8: For a checked 48-bit response, resp_err sets when the received bits 45:40 differ from the command index, or when bits 7:1 differ from the CRC7 of received bits 47:8. Unchecked and 136-bit responses never set resp_err.
- R9: The response start bit (a 0) must be seen within 64 ticks after the end bit. A start bit on the 64th tick is accepted. If all 64 ticks see a 1, resp_timeout sets, busy clears and resp_done stays 0.
- R10: An accepted command write clears resp_done, resp_timeout and resp_err.
- R11: Offsets 0x00 and 0x08 read back the last accepted command word and argument. Command-word bits 6 and 14:11 are stored but do not change the token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data for rd_addr (combinational) |
| sd_tick | input | 1 | One-cycle SD clock enable pulse |
| cmd_in | input | 1 | CMD line input from the card |
| cmd_out | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| busy | output | 1 | Command in progress |
| resp_done | output | 1 | Exchange completed |
| resp_timeout | output | 1 | No response start bit seen in time |
| resp_err | output | 1 | Index or CRC mismatch on a checked response |

## Verification
The hardest cases to reach are the response-timeout boundary and a write that arrives while a command is in progress. Both depend on where the stimulus falls relative to the tick count, not on data values. The bench counts ticks exactly and holds the CMD line high for 63 idle ticks in one run, which must still be accepted, and for 64 in another, which must time out. In a further run it writes a new command word and argument ten ticks into a token and checks that the captured token and the read-back values are unchanged. Response integrity errors are produced by building card responses in the bench with a wrong CRC or a wrong index, for each response code.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_SHORT_CHK,
    RK_SHORT_RAW,
    RK_LONG
  } resp_kind_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_WAIT,
    RX_RECV
  } rx_state_e;

  // one serial step of x^7 + x^3 + 1
  function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ {3'b000, fb, 2'b00, fb};
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] v);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_next(c, v[i]);
    return c;
  endfunction

  function automatic resp_kind_e decode_kind(input logic [2:0] code, input logic [5:0] idx);
    resp_kind_e k;
    case (code)
      3'd3:       k = RK_NONE;
      3'd4, 3'd5: k = RK_SHORT_CHK;
      3'd6:       k = RK_LONG;
      3'd7:       k = RK_SHORT_RAW;
      default: begin
        if (idx == 6'd0) k = RK_NONE;
        else if (idx == 6'd2 || idx == 6'd9 || idx == 6'd10) k = RK_LONG;
        else k = RK_SHORT_CHK;
      end
    endcase
    return k;
  endfunction

endpackage

// File: rtl/sdcf_cmd_tx.sv
module sdcf_cmd_tx #(
  parameter int TOKEN_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sd_tick,
  input  logic               start,
  input  logic [TOKEN_W-1:0] token,
  output logic               cmd_out,
  output logic               cmd_oe,
  output logic               done
);
  localparam int CNT_W = $clog2(TOKEN_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOKEN_W - 1);

  logic               active;
  logic [TOKEN_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;

  assign done    = active && sd_tick && (cnt == LAST);
  assign cmd_out = active ? shreg[TOKEN_W-1] : 1'b1;
  assign cmd_oe  = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      shreg  <= '1;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      shreg  <= token;
      cnt    <= '0;
    end else if (active && sd_tick) begin
      shreg <= {shreg[TOKEN_W-2:0], 1'b1};
      if (cnt == LAST) active <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  // token always runs its full length before the line is released
  p_tx_full_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(cnt) == LAST));

endmodule

// File: rtl/sdcf_resp_rx.sv
module sdcf_resp_rx
  import sdcf_pkg::*;
#(
  parameter int LONG_W  = 136,
  parameter int SHORT_W = 48,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd_tick,
  input  logic              arm,
  input  logic              long_sel,
  input  logic              chk_en,
  input  logic [5:0]        exp_idx,
  input  logic              cmd_in,
  output logic              done,
  output logic              timeout,
  output logic              bad,
  output logic [LONG_W-1:0] frame
);
  localparam int CNT_W    = $clog2(LONG_W + 1);
  localparam int TCNT_W   = $clog2(TIMEOUT + 1);
  localparam int CRC_SPAN = SHORT_W - 8;
  localparam int IDX_HI   = SHORT_W - 3;
  localparam int IDX_LO   = SHORT_W - 8;

  rx_state_e         state;
  logic [LONG_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [TCNT_W-1:0] tcnt;
  logic [6:0]        crc;
  logic              long_q, chk_q;
  logic [5:0]        idx_q;
  logic [CNT_W-1:0]  last_pos;
  logic              mismatch;

  assign frame    = {shreg[LONG_W-2:0], cmd_in};
  assign last_pos = long_q ? CNT_W'(LONG_W - 1) : CNT_W'(SHORT_W - 1);
  assign done     = (state == RX_RECV) && sd_tick && (cnt == last_pos);
  assign timeout  = (state == RX_WAIT) && sd_tick && cmd_in && (tcnt == TCNT_W'(TIMEOUT - 1));
  assign mismatch = (frame[IDX_HI:IDX_LO] != idx_q) || (frame[7:1] != crc);
  assign bad      = done && chk_q && mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      shreg  <= '0;
      cnt    <= '0;
      tcnt   <= '0;
      crc    <= '0;
      long_q <= 1'b0;
      chk_q  <= 1'b0;
      idx_q  <= '0;
    end else if (arm) begin
      state  <= RX_WAIT;
      shreg  <= '0;
      tcnt   <= '0;
      long_q <= long_sel;
      chk_q  <= chk_en;
      idx_q  <= exp_idx;
    end else if (sd_tick) begin
      case (state)
        RX_WAIT: begin
          if (!cmd_in) begin
            state <= RX_RECV;
            shreg <= '0;
            cnt   <= CNT_W'(1);
            crc   <= '0;
          end else if (timeout) begin
            state <= RX_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_RECV: begin
          shreg <= frame;
          if (cnt < CNT_W'(CRC_SPAN)) crc <= crc7_next(crc, cmd_in);
          if (done) state <= RX_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // a short response never puts bits above its own width into the register
  p_short_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_RECV && !long_q) |-> (shreg[LONG_W-1:SHORT_W] == '0));

  // the wait window is bounded by the timeout count
  p_wait_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_WAIT) |-> (tcnt < TCNT_W'(TIMEOUT)));

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdcf_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TIMEOUT_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              sd_tick,
  input  logic              cmd_in,
  output logic              cmd_out,
  output logic              cmd_oe,
  output logic              busy,
  output logic              resp_done,
  output logic              resp_timeout,
  output logic              resp_err
);
  localparam int TOKEN_W = 48;
  localparam int LONG_W  = 136;
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_RSP0 = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_RSP1 = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_RSP2 = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_RSP3 = ADDR_W'(8'h30);

  logic [31:0] cmd_q, arg_q, rsp0, rsp1, rsp2;
  logic [23:0] rsp3;
  resp_kind_e  kind_q, kind_new;

  logic               wr_cmd, wr_arg;
  logic [TOKEN_W-1:0] token;
  logic [39:0]        token_head;
  logic               tx_done;
  logic               rx_done, rx_timeout, rx_bad;
  logic [LONG_W-1:0]  rx_frame;

  assign wr_cmd     = wr_en && (wr_addr == A_CMD) && !busy;
  assign wr_arg     = wr_en && (wr_addr == A_ARG) && !busy;
  assign kind_new   = decode_kind(wr_data[10:8], wr_data[5:0]);
  assign token_head = {2'b01, wr_data[5:0], arg_q};
  assign token      = {token_head, crc7_of40(token_head), 1'b1};

  sdcf_cmd_tx #(.TOKEN_W(TOKEN_W)) tx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sd_tick (sd_tick),
    .start   (wr_cmd),
    .token   (token),
    .cmd_out (cmd_out),
    .cmd_oe  (cmd_oe),
    .done    (tx_done)
  );

  sdcf_resp_rx #(.LONG_W(LONG_W), .SHORT_W(TOKEN_W), .TIMEOUT(TIMEOUT_TICKS)) rx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_tick  (sd_tick),
    .arm      (tx_done && (kind_q != RK_NONE)),
    .long_sel (kind_q == RK_LONG),
    .chk_en   (kind_q == RK_SHORT_CHK),
    .exp_idx  (cmd_q[5:0]),
    .cmd_in   (cmd_in),
    .done     (rx_done),
    .timeout  (rx_timeout),
    .bad      (rx_bad),
    .frame    (rx_frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q        <= '0;
      arg_q        <= '0;
      kind_q       <= RK_NONE;
      busy         <= 1'b0;
      resp_done    <= 1'b0;
      resp_timeout <= 1'b0;
      resp_err     <= 1'b0;
      rsp0         <= '0;
      rsp1         <= '0;
      rsp2         <= '0;
      rsp3         <= '0;
    end else begin
      if (wr_arg) arg_q <= wr_data;
      if (wr_cmd) begin
        cmd_q        <= wr_data;
        kind_q       <= kind_new;
        busy         <= 1'b1;
        resp_done    <= 1'b0;
        resp_timeout <= 1'b0;
        resp_err     <= 1'b0;
      end
      if (tx_done && kind_q == RK_NONE) begin
        busy      <= 1'b0;
        resp_done <= 1'b1;
      end
      if (rx_done) begin
        busy      <= 1'b0;
        resp_done <= 1'b1;
        resp_err  <= rx_bad;
        rsp0      <= rx_frame[39:8];
        if (kind_q == RK_LONG) begin
          rsp1 <= rx_frame[71:40];
          rsp2 <= rx_frame[103:72];
          rsp3 <= rx_frame[127:104];
        end else begin
          rsp1 <= '0;
          rsp2 <= '0;
          rsp3 <= '0;
        end
      end
      if (rx_timeout) begin
        busy         <= 1'b0;
        resp_timeout <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_CMD:   rd_data = cmd_q;
      A_ARG:   rd_data = arg_q;
      A_RSP0:  rd_data = rsp0;
      A_RSP1:  rd_data = rsp1;
      A_RSP2:  rd_data = rsp2;
      A_RSP3:  rd_data = {8'h00, rsp3};
      default: rd_data = '0;
    endcase
  end

  p_oe_inside_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> busy);

  p_cmd_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> ($stable(cmd_q) && $stable(arg_q)));

  p_busy_fall_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (resp_done || resp_timeout));

  p_outcome_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_done && resp_timeout));

endmodule

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        sd_tick = 1'b0;
  logic        cmd_in = 1'b1;
  logic        cmd_out, cmd_oe, busy, resp_done, resp_timeout, resp_err;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sd_cmd_engine #(.ADDR_W(8), .TIMEOUT_TICKS(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sd_tick(sd_tick), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .resp_done(resp_done),
    .resp_timeout(resp_timeout), .resp_err(resp_err)
  );

  function automatic logic [6:0] ref_crc(input logic [39:0] v);
    logic [6:0] c = '0;
    for (int i = 39; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [47:0] ref_token(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, ref_crc({2'b01, idx, arg}), 1'b1};
  endfunction

  function automatic logic [47:0] short_resp(input logic [5:0] idx, input logic [31:0] pl);
    return {2'b00, idx, pl, ref_crc({2'b00, idx, pl}), 1'b1};
  endfunction

  function automatic logic [135:0] long_resp(input logic [31:0] seed);
    return {2'b00, 6'h3f, seed, ~seed, seed ^ 32'h5a5a_5a5a, 24'h123456, 7'h55, 1'b1};
  endfunction

  task automatic check(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic tick(input logic din, output logic seen);
    @(negedge clk);
    sd_tick = 1'b1;
    cmd_in = din;
    seen = cmd_out;
    @(negedge clk);
    sd_tick = 1'b0;
    cmd_in = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  // full exchange: token capture, optional idle ticks and response bits
  task automatic do_cmd(input logic [31:0] cw, input logic [31:0] arg, input int delay,
                        input int rlen, input logic [135:0] rbits, input bit midwrite,
                        output logic [47:0] tok);
    logic s;
    bus_write(8'h08, arg);
    bus_write(8'h00, cw);
    for (int k = 0; k < 48; k++) begin
      if (midwrite && k == 10) begin
        bus_write(8'h00, 32'h0000_0311);
        bus_write(8'h08, 32'hdead_beef);
      end
      tick(1'b1, s);
      tok[47-k] = s;
    end
    if (rlen > 0) begin
      for (int k = 0; k < delay; k++) tick(1'b1, s);
      for (int k = 0; k < rlen; k++) tick(rbits[rlen-1-k], s);
    end
  endtask

  task automatic check_regs(input string req, input logic [31:0] e0, input logic [31:0] e1,
                            input logic [31:0] e2, input logic [31:0] e3);
    logic [31:0] v0, v1, v2, v3;
    bus_read(8'h18, v0); bus_read(8'h20, v1); bus_read(8'h28, v2); bus_read(8'h30, v3);
    check({v0, v1, v2, v3} == {e0, e1, e2, e3}, req, {v0, v1, v2, v3}, {e0, e1, e2, e3});
  endtask

  initial begin
    #(150000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
  end

  initial begin
    logic [47:0]  tok;
    logic [31:0]  v;
    logic [135:0] lr;
    logic [47:0]  sr;
    logic [31:0]  pl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check({busy, resp_done, resp_timeout, resp_err, cmd_oe, cmd_out} == 6'b000001, "R1 flags",
          {busy, resp_done, resp_timeout, resp_err, cmd_oe, cmd_out}, 6'b000001);
    for (int a = 0; a < 64; a += 8) begin
      bus_read(8'(a), v);
      check(v == 32'h0, "R1 readback", v, 0);
    end

    // R2/R5 sweep of every index with no response (code 3)
    for (int i = 0; i < 64; i++) begin
      logic [31:0] arg = (32'(i) * 32'h0101_0101) ^ 32'ha5c3_1e07;
      bus_write(8'h08, arg);
      bus_write(8'h00, 32'h0000_0300 | 32'(i));
      check(busy == 1'b1, "R3 busy after write", busy, 1);
      for (int k = 0; k < 48; k++) begin
        logic s;
        tick(1'b1, s);
        tok[47-k] = s;
      end
      check(tok == ref_token(6'(i), arg), "R2 token", tok, ref_token(6'(i), arg));
      check(resp_done && !busy && !resp_timeout, "R5 done at end bit",
            {resp_done, busy, resp_timeout}, 3'b100);
    end

    // R11: flag bits stored but token unchanged
    do_cmd(32'h0000_7b51, 32'h1234_5678, 0, 0, '0, 1'b0, tok);
    check(tok == ref_token(6'd17, 32'h1234_5678), "R11 token ignores flags", tok,
          ref_token(6'd17, 32'h1234_5678));
    bus_read(8'h00, v);
    check(v == 32'h0000_7b51, "R11 command readback", v, 32'h0000_7b51);

    // R3: writes during a command are ignored
    do_cmd(32'h0000_0305, 32'hcafe_0001, 0, 0, '0, 1'b1, tok);
    check(tok == ref_token(6'd5, 32'hcafe_0001), "R3 token kept", tok, ref_token(6'd5, 32'hcafe_0001));
    bus_read(8'h00, v);
    check(v == 32'h0000_0305, "R3 command kept", v, 32'h0000_0305);
    bus_read(8'h08, v);
    check(v == 32'hcafe_0001, "R3 argument kept", v, 32'hcafe_0001);

    // R7/R8: long response (code 6), CRC field not checked
    lr = long_resp(32'h89ab_cdef);
    do_cmd(32'h0000_0602, 32'h0, 3, 136, lr, 1'b0, tok);
    check(resp_done && !busy && !resp_err, "R7 long done", {resp_done, busy, resp_err}, 3'b100);
    check_regs("R7 long mapping", lr[39:8], lr[71:40], lr[103:72], {8'h00, lr[127:104]});

    // R6: short checked response (code 4) clears the upper registers
    pl = 32'h0bad_f00d;
    sr = short_resp(6'd13, pl);
    do_cmd(32'h0000_040d, 32'h0000_1000, 5, 48, 136'(sr), 1'b0, tok);
    check(resp_done && !busy && !resp_err, "R6 short done", {resp_done, busy, resp_err}, 3'b100);
    check_regs("R6 short mapping", pl, 0, 0, 0);

    // R8: code 7 with wrong CRC and index 3f reports no error
    sr = {2'b00, 6'h3f, 32'h00ff_8000, 7'h7f, 1'b1};
    do_cmd(32'h0000_0729, 32'h0, 0, 48, 136'(sr), 1'b0, tok);
    check(resp_done && !resp_err, "R8 unchecked response", {resp_done, resp_err}, 2'b10);
    check_regs("R6 unchecked payload", 32'h00ff_8000, 0, 0, 0);

    // R8: code 5 with bad CRC
    sr = short_resp(6'd7, 32'h1111_2222) ^ 48'h2;
    do_cmd(32'h0000_0507, 32'h0, 2, 48, 136'(sr), 1'b0, tok);
    check(resp_done && resp_err, "R8 crc mismatch", {resp_done, resp_err}, 2'b11);

    // R10: new command clears flags
    bus_write(8'h00, 32'h0000_0401);
    check(busy && !resp_done && !resp_err && !resp_timeout, "R10 flags cleared",
          {busy, resp_done, resp_err, resp_timeout}, 4'b1000);
    for (int k = 0; k < 48; k++) begin
      logic s;
      tick(1'b1, s);
    end
    // R8: wrong index with valid CRC over it
    sr = short_resp(6'd2, 32'h4444_5555);
    for (int k = 0; k < 48; k++) begin
      logic s;
      tick(sr[47-k], s);
    end
    check(resp_done && resp_err, "R8 index mismatch", {resp_done, resp_err}, 2'b11);

    // R4: auto-detect codes
    do_cmd(32'h0000_0000, 32'h0, 0, 0, '0, 1'b0, tok);
    check(resp_done && !busy, "R4 auto index 0 no response", {resp_done, busy}, 2'b10);
    lr = long_resp(32'h0f0f_3c3c);
    do_cmd(32'h0000_0009, 32'h0, 1, 136, lr, 1'b0, tok);
    check(resp_done && !resp_err, "R4 auto index 9 long", {resp_done, resp_err}, 2'b10);
    check_regs("R4 auto long mapping", lr[39:8], lr[71:40], lr[103:72], {8'h00, lr[127:104]});
    lr = long_resp(32'h7777_0000);
    do_cmd(32'h0000_010a, 32'h0, 1, 136, lr, 1'b0, tok);
    check_regs("R4 code 1 index 10 long", lr[39:8], lr[71:40], lr[103:72], {8'h00, lr[127:104]});
    sr = short_resp(6'd8, 32'h0000_01aa) ^ 48'h4;
    do_cmd(32'h0000_0208, 32'h0000_01aa, 0, 48, 136'(sr), 1'b0, tok);
    check(resp_done && resp_err, "R4 code 2 index 8 checked short", {resp_done, resp_err}, 2'b11);

    // R9: start bit on the 64th tick still accepted
    sr = short_resp(6'd3, 32'h9999_0000);
    do_cmd(32'h0000_0403, 32'h0, 63, 48, 136'(sr), 1'b0, tok);
    check(resp_done && !resp_timeout && !resp_err, "R9 63 idle ticks ok",
          {resp_done, resp_timeout, resp_err}, 3'b100);

    // R9: 64 idle ticks times out
    do_cmd(32'h0000_0403, 32'h0, 0, 0, '0, 1'b0, tok);
    for (int k = 0; k < 63; k++) begin
      logic s;
      tick(1'b1, s);
    end
    check(busy && !resp_timeout, "R9 still waiting at 63", {busy, resp_timeout}, 2'b10);
    begin
      logic s;
      tick(1'b1, s);
    end
    check(!busy && resp_timeout && !resp_done, "R9 timeout", {busy, resp_timeout, resp_done}, 3'b010);

    report();
  end

endmodule